// File: doc/BRIEF.md
# ADC Sample Capture FIFO

This block sits between a 12-bit two's-complement sampling converter and a host. Each time the converter signals a finished conversion, the block sign-extends the 12-bit result to a 16-bit word and stores it in a 512-word first-in first-out buffer. No host action is needed, and the converter may deliver its next result on the very next cycle. The host removes the oldest word whenever it has time, which gives software up to 512 sample periods of slack.

Fill status is exposed as a word count with empty and full flags. When a result arrives while 512 unread words are held, that result is discarded and a sticky error flag is raised. The stored words are kept, so the oldest data survives. Only a clear pulse from the host lowers the flag.

The sample input is a valid-only stream with no back-pressure. A result offered while the buffer is full and not being read is dropped and flagged. On the host side, `rd_req` acts as the ready of the output stream. A request while words are held pops the oldest word. `rd_valid` pulses one cycle later, and `rd_data` then holds that word until the next successful pop. A request while empty is ignored. The design has one clock domain and a synchronous reset.

Top module: `adc_capture_fifo`

## Requirements
- R1: A sample is stored sign-extended: bits 15..12 of the stored word equal bit 11 of the sample, and bits 11..0 equal the sample (for example, 12'h800 becomes 16'hF800 and 12'h7FF becomes 16'h07FF).
- R2: Words leave in arrival order. A `rd_req` while not empty makes `rd_valid` high and places the oldest word on `rd_data` in the following cycle.
- R3: 512 samples written with no read are all retained, and they read back in order.
- R4: A sample with `smp_valid` high while `full` is high and `rd_req` is low is discarded. The count stays at 512, the stored words are unchanged, and `ovf_err` is high from the next cycle.
- R5: `ovf_err` stays high through reads and idle cycles until `ovf_clr` is pulsed; it is low in the cycle after the clear. If an overflow and a clear happen in the same cycle, the flag stays set.
- R6: A `rd_req` while `empty` is high leaves `rd_valid` low, leaves `rd_data` at its previous value and leaves the count at 0.
- R7: When `full` is high and `smp_valid` and `rd_req` are both high, the oldest word is read out and the new sample is stored. The count stays at 512 and no overflow is flagged.
- R8: `fill_count` follows accepted writes minus pops, one cycle after them, within 0..512. `empty` is high exactly at 0 and `full` is high exactly at 512.
- R9: While reset is high, and in the first cycle after it, the count is 0, `empty` is 1, `full` is 0, `ovf_err` is 0, `rd_valid` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Conversion-done strobe, one sample per high cycle |
| smp_data | input | 12 | Two's-complement converter result |
| rd_req | input | 1 | Host request to pop the oldest word |
| ovf_clr | input | 1 | Pulse to clear the overflow flag |
| rd_valid | output | 1 | High for one cycle after a successful pop |
| rd_data | output | 16 | Last popped word, held between pops |
| fill_count | output | 10 | Number of unread words, 0..512 |
| empty | output | 1 | No unread words |
| full | output | 1 | 512 unread words |
| ovf_err | output | 1 | Sticky overflow error flag |

## Verification
The bench fills the buffer to exactly 512 words and offers one more sample. A design with an off-by-one depth would either lose a word early or accept the extra sample over the oldest data. It then pops and pushes in the same cycle at full, where a design that checks full before the pop would wrongly flag overflow or drop the sample. It also reads while empty after non-zero data has gone out, which catches a design that moves its read pointer or changes `rd_data`. Finally, it clears the flag in the same cycle as an overflow, and it feeds samples with bit 11 set to catch zero-extension.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int SMP_W_DEF  = 12;
  localparam int WORD_W_DEF = 16;
  localparam int DEPTH_DEF  = 512;

  typedef struct packed {
    logic push;   // sample accepted into storage
    logic pop;    // oldest word removed
    logic drop;   // sample lost to a full buffer
  } fifo_op_t;
endpackage

// File: rtl/adc_cap_sext.sv
module adc_cap_sext #(
  parameter int IN_W  = adc_cap_pkg::SMP_W_DEF,
  parameter int OUT_W = adc_cap_pkg::WORD_W_DEF
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD_W = (OUT_W > IN_W) ? OUT_W - IN_W : 1;

  generate
    if (OUT_W > IN_W) begin : g_pad
      assign dout = {{PAD_W{din[IN_W-1]}}, din};
    end else begin : g_trunc
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int DEPTH = DEPTH_DEF,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic          rd_req,
  input  logic          ovf_clr,
  output fifo_op_t      op,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          ovf_err
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam bit POW2 = (DEPTH == (1 << AW));

  assign empty = (count == '0);
  assign full  = (count == CNT_MAX);

  // A pop in the same cycle frees a slot, so full does not block that push.
  always_comb begin
    op.pop  = rd_req && !empty;
    op.push = smp_valid && (!full || op.pop);
    op.drop = smp_valid && full && !op.pop;
  end

  logic [AW-1:0] wr_nxt, rd_nxt;

  generate
    if (POW2) begin : g_wrap_nat
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      ovf_err <= 1'b0;
    end else begin
      if (op.push) wr_ptr <= wr_nxt;
      if (op.pop)  rd_ptr <= rd_nxt;
      case ({op.push, op.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      // a new loss outranks a clear in the same cycle
      ovf_err <= op.drop || (ovf_err && !ovf_clr);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_MAX); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && smp_valid && !rd_req) |=> (ovf_err && full)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_err && !ovf_clr) |=> ovf_err); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !(smp_valid && full && !rd_req)) |=> !ovf_err); // R5
  AST_FULL_RW: assert property (@(posedge clk) disable iff (rst)
    (full && smp_valid && rd_req && !ovf_err) |=> (full && !ovf_err)); // R7
endmodule

// File: rtl/adc_cap_mem.sv
module adc_cap_mem #(
  parameter int WORD_W = adc_cap_pkg::WORD_W_DEF,
  parameter int DEPTH  = adc_cap_pkg::DEPTH_DEF,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);
  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Read before write: at full, a pop and a push share one address.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= store[raddr];
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata)); // R6
endmodule

// File: rtl/adc_capture_fifo.sv
module adc_capture_fifo
  import adc_cap_pkg::*;
#(
  parameter int SMP_W  = SMP_W_DEF,
  parameter int WORD_W = WORD_W_DEF,
  parameter int DEPTH  = DEPTH_DEF,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              rd_req,
  input  logic              ovf_clr,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [CW-1:0]     fill_count,
  output logic              empty,
  output logic              full,
  output logic              ovf_err
);
  fifo_op_t          op;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [WORD_W-1:0] word_in;

  adc_cap_sext #(.IN_W(SMP_W), .OUT_W(WORD_W)) u_sext (
    .din  (smp_data),
    .dout (word_in)
  );

  adc_cap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .rd_req    (rd_req),
    .ovf_clr   (ovf_clr),
    .op        (op),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .count     (fill_count),
    .empty     (empty),
    .full      (full),
    .ovf_err   (ovf_err)
  );

  adc_cap_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk    (clk),
    .rst    (rst),
    .we     (op.push),
    .waddr  (wr_ptr),
    .wdata  (word_in),
    .re     (op.pop),
    .raddr  (rd_ptr),
    .rdata  (rd_data),
    .rvalid (rd_valid)
  );

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty) |=> !rd_valid); // R6
  AST_EMPTY_READ_KEEP: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty && !smp_valid) |=> empty); // R6
endmodule

// File: tb/adc_capture_fifo_bench.sv
`timescale 1ns/1ps
module adc_capture_fifo_bench;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        rd_req = 1'b0;
  logic        ovf_clr = 1'b0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [9:0]  fill_count;
  logic        empty, full, ovf_err;

  always #2.5 clk = ~clk;

  adc_capture_fifo u_adc_capture_fifo (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .rd_req(rd_req), .ovf_clr(ovf_clr), .rd_valid(rd_valid), .rd_data(rd_data),
    .fill_count(fill_count), .empty(empty), .full(full), .ovf_err(ovf_err)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference
  int   q[$];
  bit   m_valid = 0;
  int   m_data = 0;
  bit   m_ovf = 0;

  function automatic int widen(input logic [11:0] s);
    logic signed [15:0] w;
    w = $signed(s);
    return int'(w) & 32'hFFFF;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_valid = 0; m_data = 0; m_ovf = 0;
    end else begin
      bit pop, fl, push, drop;
      pop  = rd_req && (q.size() > 0);
      fl   = (q.size() == DEPTH);
      push = smp_valid && (!fl || pop);
      drop = smp_valid && fl && !pop;
      m_valid = pop;
      if (pop) m_data = q.pop_front();
      if (push) q.push_back(widen(smp_data));
      m_ovf = drop || (m_ovf && !ovf_clr);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2 rd_valid", int'(rd_valid), int'(m_valid));
      chk("R2 rd_data", int'(rd_data), m_data);
      chk("R8 fill_count", int'(fill_count), q.size());
      chk("R8 empty", int'(empty), int'(q.size() == 0));
      chk("R8 full", int'(full), int'(q.size() == DEPTH));
      chk("R5 ovf_err", int'(ovf_err), int'(m_ovf));
    end
  end

  task automatic drive(input bit v, input logic [11:0] d, input bit r, input bit c);
    @(negedge clk);
    smp_valid = v; smp_data = d; rd_req = r; ovf_clr = c;
  endtask

  task automatic idle();
    drive(0, '0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] pats [4];
    int exp_w [4];
    pats[0] = 12'h7FF; pats[1] = 12'h800; pats[2] = 12'hFFF; pats[3] = 12'h001;
    exp_w[0] = 16'h07FF; exp_w[1] = 16'hF800; exp_w[2] = 16'hFFFF; exp_w[3] = 16'h0001;

    repeat (3) @(negedge clk);
    // R9: reset state while reset is held
    chk("R9 count", int'(fill_count), 0);
    chk("R9 empty", int'(empty), 1);
    chk("R9 full", int'(full), 0);
    chk("R9 ovf", int'(ovf_err), 0);
    chk("R9 rd_valid", int'(rd_valid), 0);
    chk("R9 rd_data", int'(rd_data), 0);
    rst = 1'b0;

    // R6: read while empty
    drive(0, '0, 1, 0);
    idle();
    chk("R6 empty rd_valid", int'(rd_valid), 0);
    chk("R6 empty rd_data", int'(rd_data), 0);
    chk("R6 empty count", int'(fill_count), 0);

    // R1 / R2: sign extension and order
    for (int i = 0; i < 4; i++) drive(1, pats[i], 0, 0);
    idle();
    chk("R8 count after 4", int'(fill_count), 4);
    for (int i = 0; i < 4; i++) begin
      drive(0, '0, 1, 0);
      idle();
      chk("R2 pop valid", int'(rd_valid), 1);
      chk("R1 sign-extended word", int'(rd_data), exp_w[i]);
    end
    // R6: empty read keeps last word
    drive(0, '0, 1, 0);
    idle();
    chk("R6 hold rd_data", int'(rd_data), 16'h0001);
    chk("R6 hold rd_valid", int'(rd_valid), 0);

    // R3: fill to capacity
    for (int i = 0; i < DEPTH; i++) drive(1, 12'((i * 7) & 12'hFFF), 0, 0);
    idle();
    chk("R3 full", int'(full), 1);
    chk("R3 count 512", int'(fill_count), 512);
    chk("R3 no ovf", int'(ovf_err), 0);

    // R4: extra sample lost, oldest kept
    drive(1, 12'hABC, 0, 0);
    idle();
    chk("R4 ovf set", int'(ovf_err), 1);
    chk("R4 count kept", int'(fill_count), 512);
    drive(0, '0, 1, 0);
    idle();
    chk("R4 oldest kept", int'(rd_data), 0);
    chk("R5 sticky after read", int'(ovf_err), 1);
    repeat (3) idle();
    chk("R5 sticky idle", int'(ovf_err), 1);

    // R5: clear
    drive(0, '0, 0, 1);
    idle();
    chk("R5 cleared", int'(ovf_err), 0);

    // R7: simultaneous read and write at full
    drive(1, 12'h123, 0, 0);
    idle();
    chk("R7 refilled", int'(full), 1);
    drive(1, 12'h456, 1, 0);
    idle();
    chk("R7 no ovf", int'(ovf_err), 0);
    chk("R7 count 512", int'(fill_count), 512);
    chk("R7 read oldest", int'(rd_data), 7);

    // R5: overflow and clear in the same cycle keeps the flag
    drive(1, 12'h111, 0, 1);
    idle();
    chk("R5 set wins", int'(ovf_err), 1);
    drive(0, '0, 0, 1);

    // mixed random traffic, model compares every cycle (R2, R8)
    for (int i = 0; i < 6000; i++) begin
      int rv;
      rv = $urandom;
      drive(((rv & 3) != 0), 12'(rv >>> 4), ((rv & 12) != 0) || (i > 3000 && (rv & 16) != 0),
            (rv & 32'h3F00) == 0);
    end
    // drain
    for (int i = 0; i < DEPTH + 4; i++) drive(0, '0, 1, 0);
    idle();
    chk("R8 drained empty", int'(empty), 1);
    chk("R8 drained count", int'(fill_count), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule